// File: doc/BRIEF.md
# Quadrature Digital Downmixer

This block turns a stream of signed real samples into in-phase and quadrature products. Each accepted sample is multiplied by the cosine and the sine of a local numerically controlled oscillator. The two results leave the block together on registered I and Q words with a single valid strobe. The oscillator is a 32-bit phase accumulator. Software sets its frequency by writing a phase increment and can shift its phase with a separate offset word.

The multiplier has a complex input. Its imaginary half is tied to zero inside the block, so the block acts as a real-to-complex downconverter. Sine and cosine come from one quarter-wave table that the RTL computes at elaboration. The table is addressed by the upper phase bits and unfolded by quadrant symmetry. Products are rounded back to the sample width and saturated.

Top module: `iq_downmix`

## Requirements
- R1: While `rst_n` is low and after its release, `out_vld`, `i_out` and `q_out` are zero. The accumulator, phase increment and phase offset are also zero, so the first sample after reset sees phase 0.
- R2: Each sample with `sample_vld` high is mixed at phase `acc + offset` (modulo 2^32). Only the upper 20 bits of that sum are kept. The accumulator then advances by the increment. In cycles without a valid sample it holds.
- R3: A write with `cfg_we` high stores `cfg_wdata` in one of two registers. `cfg_sel` = 0 selects the phase increment and `cfg_sel` = 1 selects the phase offset. A sample in the same cycle as the write still uses the old increment and offset. The new value applies from the next sample onward, and a write never resets the accumulator.
- R4: Let k be the top 10 bits of the 32-bit mixing phase (8 table-address bits plus 2 quadrant bits). The cosine coefficient is round(32767·cos(2π(k+0.5)/1024)) and the sine coefficient is the same expression with sin. Each coefficient is within 1 LSB of that value.
- R5: The outputs are `i_out` = sample·cos and `q_out` = sample·sin. Each product has 2^14 added, is arithmetically shifted right by 15 and is saturated to 16 signed bits. Each output is within 1 LSB of that value computed with the ideal R4 coefficients.
- R6: A sample accepted at clock edge n appears on the outputs after edge n+2, with `out_vld` high for exactly that one cycle. `out_vld` follows `sample_vld` with a latency of 3 edges.
- R7: When no result is due, `i_out` and `q_out` keep their previous values.
- R8: Full-scale samples (-32768 and 32767) give results of the correct sign that never wrap, and neither output ever reads -32768.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sample_vld | input | 1 | Marks a valid input sample this cycle |
| sample_in | input | 16 | Signed input sample |
| cfg_we | input | 1 | Control-bus write strobe |
| cfg_sel | input | 1 | Register select: 0 phase increment, 1 phase offset |
| cfg_wdata | input | 32 | Control-bus write data |
| i_out | output | 16 | Signed in-phase result |
| q_out | output | 16 | Signed quadrature result |
| out_vld | output | 1 | Marks valid I and Q results |

## Verification
A control-bus write and an accepted sample can land in the same cycle. The sample must then be mixed with the increment and offset in force before the write, and the accumulator must advance by the old increment. Directed cycles place writes to both registers exactly on valid samples, and random stimulus adds such collisions at a low rate. A bench model applies the write only after it has processed that cycle's sample and computes the expected phase from that ordering. It then compares the I and Q words three edges later.

// File: rtl/iq_downmix_pkg.sv
package iq_downmix_pkg;

  typedef enum logic {
    SEL_STEP   = 1'b0,
    SEL_OFFSET = 1'b1
  } cfg_sel_e;

  localparam longint QONE    = 64'sd1073741824;
  localparam longint QHALFPI = 64'sd1686629713;

  // Sine at the centre of table cell idx of a quarter wave, scaled to amp.
  // Fixed-point Q30 Taylor series, evaluated at elaboration time.
  function automatic int quarter_sine(input int idx, input int depth, input int amp);
    longint x;
    longint term;
    longint sum;
    x    = ((2 * longint'(idx) + 1) * QHALFPI) / (2 * longint'(depth));
    term = x;
    sum  = x;
    for (int k = 1; k <= 7; k++) begin
      term = -((term * x) / QONE);
      term = (term * x) / QONE;
      term = term / longint'((2 * k) * (2 * k + 1));
      sum  = sum + term;
    end
    return int'((sum * longint'(amp) + (QONE / 2)) / QONE);
  endfunction

endpackage

// File: rtl/iq_downmix_cfg.sv
module iq_downmix_cfg
  import iq_downmix_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [ACC_W-1:0] cfg_wdata,
  output logic [ACC_W-1:0] step_q,
  output logic [ACC_W-1:0] off_q
);

  logic [ACC_W-1:0] step_nxt;
  logic [ACC_W-1:0] off_nxt;

  always_comb begin
    step_nxt = step_q;
    off_nxt  = off_q;
    if (cfg_we) begin
      if (cfg_sel_e'(cfg_sel) == SEL_STEP) begin
        step_nxt = cfg_wdata;
      end else begin
        off_nxt = cfg_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      off_q  <= '0;
    end else begin
      step_q <= step_nxt;
      off_q  <= off_nxt;
    end
  end

endmodule

// File: rtl/iq_downmix_acc.sv
module iq_downmix_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [ACC_W-1:0] step,
  output logic [ACC_W-1:0] acc_q
);

  logic [ACC_W-1:0] acc_nxt;

  always_comb begin
    acc_nxt = acc_q;
    if (en) begin
      acc_nxt = acc_q + step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_nxt;
    end
  end

endmodule

// File: rtl/iq_downmix_sincos.sv
module iq_downmix_sincos
  import iq_downmix_pkg::*;
#(
  parameter int TBL_W  = 10,
  parameter int COEF_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [TBL_W-1:0]         ph,
  output logic signed [COEF_W-1:0] cos_q,
  output logic signed [COEF_W-1:0] sin_q
);

  localparam int LUT_AW = TBL_W - 2;
  localparam int DEPTH  = 1 << LUT_AW;
  localparam int AMP    = (1 << (COEF_W - 1)) - 1;

  logic [COEF_W-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    localparam int VAL = quarter_sine(g, DEPTH, AMP);
    assign rom[g] = COEF_W'(VAL);
  end

  logic [1:0]               quad;
  logic [LUT_AW-1:0]        idx;
  logic [LUT_AW-1:0]        idx_s;
  logic [LUT_AW-1:0]        idx_c;
  logic [COEF_W-1:0]        mag_s;
  logic [COEF_W-1:0]        mag_c;
  logic signed [COEF_W-1:0] sin_nxt;
  logic signed [COEF_W-1:0] cos_nxt;

  always_comb begin
    quad  = ph[TBL_W-1 -: 2];
    idx   = ph[LUT_AW-1:0];
    idx_s = quad[0] ? ~idx : idx;
    idx_c = quad[0] ? idx : ~idx;
    mag_s = rom[idx_s];
    mag_c = rom[idx_c];
    sin_nxt = sin_q;
    cos_nxt = cos_q;
    if (en) begin
      sin_nxt = quad[1] ? -$signed(mag_s) : $signed(mag_s);
      cos_nxt = (quad[1] ^ quad[0]) ? -$signed(mag_c) : $signed(mag_c);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sin_q <= '0;
      cos_q <= '0;
    end else begin
      sin_q <= sin_nxt;
      cos_q <= cos_nxt;
    end
  end

endmodule

// File: rtl/iq_downmix_cmul.sv
module iq_downmix_cmul #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     vld_in,
  input  logic signed [DATA_W-1:0] re,
  input  logic signed [DATA_W-1:0] im,
  input  logic signed [COEF_W-1:0] cos_c,
  input  logic signed [COEF_W-1:0] sin_c,
  output logic signed [DATA_W-1:0] i_q,
  output logic signed [DATA_W-1:0] q_q,
  output logic                     vld_q
);

  localparam int MUL_W  = DATA_W + COEF_W;
  localparam int PROD_W = MUL_W + 1;
  localparam int SH     = COEF_W - 1;
  localparam logic signed [PROD_W-1:0] MAXV = PROD_W'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [PROD_W-1:0] MINV = ~MAXV;
  localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1 << (SH - 1));

  function automatic logic signed [DATA_W-1:0] rnd_sat(input logic signed [PROD_W-1:0] v);
    logic signed [PROD_W-1:0] r;
    r = (v + HALF) >>> SH;
    if (r > MAXV) begin
      return DATA_W'(MAXV);
    end else if (r < MINV) begin
      return DATA_W'(MINV);
    end
    return DATA_W'(r);
  endfunction

  logic signed [MUL_W-1:0]  p_rc;
  logic signed [MUL_W-1:0]  p_is;
  logic signed [MUL_W-1:0]  p_rs;
  logic signed [MUL_W-1:0]  p_ic;
  logic signed [PROD_W-1:0] sum_i;
  logic signed [PROD_W-1:0] sum_q;
  logic signed [DATA_W-1:0] i_nxt;
  logic signed [DATA_W-1:0] q_nxt;

  always_comb begin
    p_rc  = re * cos_c;
    p_is  = im * sin_c;
    p_rs  = re * sin_c;
    p_ic  = im * cos_c;
    sum_i = PROD_W'(p_rc) - PROD_W'(p_is);
    sum_q = PROD_W'(p_rs) + PROD_W'(p_ic);
    i_nxt = i_q;
    q_nxt = q_q;
    if (vld_in) begin
      i_nxt = rnd_sat(sum_i);
      q_nxt = rnd_sat(sum_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_q   <= '0;
      q_q   <= '0;
      vld_q <= 1'b0;
    end else begin
      i_q   <= i_nxt;
      q_q   <= q_nxt;
      vld_q <= vld_in;
    end
  end

endmodule

// File: rtl/iq_downmix.sv
module iq_downmix
  import iq_downmix_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 32,
  parameter int PH_W   = 20,
  parameter int LUT_AW = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sample_vld,
  input  logic signed [DATA_W-1:0] sample_in,
  input  logic                     cfg_we,
  input  logic                     cfg_sel,
  input  logic [ACC_W-1:0]         cfg_wdata,
  output logic signed [DATA_W-1:0] i_out,
  output logic signed [DATA_W-1:0] q_out,
  output logic                     out_vld
);

  localparam int TBL_W = LUT_AW + 2;

  logic [ACC_W-1:0]         step_q;
  logic [ACC_W-1:0]         off_q;
  logic [ACC_W-1:0]         acc_q;

  logic [PH_W-1:0]          ph_s1;
  logic [PH_W-1:0]          ph_nxt;
  logic signed [DATA_W-1:0] smp_s1;
  logic signed [DATA_W-1:0] smp_s1_nxt;
  logic                     v_s1;
  logic signed [DATA_W-1:0] smp_s2;
  logic signed [DATA_W-1:0] smp_s2_nxt;
  logic                     v_s2;
  logic [TBL_W-1:0]         tbl_ph;
  logic signed [COEF_W-1:0] cos_s2;
  logic signed [COEF_W-1:0] sin_s2;

  iq_downmix_cfg #(.ACC_W(ACC_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .step_q    (step_q),
    .off_q     (off_q)
  );

  iq_downmix_acc #(.ACC_W(ACC_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (sample_vld),
    .step  (step_q),
    .acc_q (acc_q)
  );

  // Stage 1: capture the mixing phase and the sample
  always_comb begin
    ph_nxt     = ph_s1;
    smp_s1_nxt = smp_s1;
    if (sample_vld) begin
      ph_nxt     = PH_W'((acc_q + off_q) >> (ACC_W - PH_W));
      smp_s1_nxt = sample_in;
    end
  end

  // Stage 2 companion: delay the sample alongside the table lookup
  always_comb begin
    smp_s2_nxt = smp_s2;
    if (v_s1) begin
      smp_s2_nxt = smp_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_s1  <= '0;
      smp_s1 <= '0;
      v_s1   <= 1'b0;
      smp_s2 <= '0;
      v_s2   <= 1'b0;
    end else begin
      ph_s1  <= ph_nxt;
      smp_s1 <= smp_s1_nxt;
      v_s1   <= sample_vld;
      smp_s2 <= smp_s2_nxt;
      v_s2   <= v_s1;
    end
  end

  assign tbl_ph = TBL_W'(ph_s1 >> (PH_W - TBL_W));

  iq_downmix_sincos #(.TBL_W(TBL_W), .COEF_W(COEF_W)) u_sincos (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (v_s1),
    .ph    (tbl_ph),
    .cos_q (cos_s2),
    .sin_q (sin_s2)
  );

  // Stage 3: complex multiply with the imaginary input tied to zero
  iq_downmix_cmul #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_cmul (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld_in (v_s2),
    .re     (smp_s2),
    .im     ('0),
    .cos_c  (cos_s2),
    .sin_c  (sin_s2),
    .i_q    (i_out),
    .q_q    (q_out),
    .vld_q  (out_vld)
  );

endmodule

// File: rtl/iq_downmix_chk.sv
module iq_downmix_chk #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     sample_vld,
  input logic [ACC_W-1:0]         acc_q,
  input logic [ACC_W-1:0]         step_q,
  input logic                     out_vld,
  input logic signed [DATA_W-1:0] i_out,
  input logic signed [DATA_W-1:0] q_out
);

  localparam logic signed [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= 2'd0;
    end else if (since_rst != 2'd3) begin
      since_rst <= since_rst + 2'd1;
    end
  end

  AST_ACC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |=> (acc_q == $past(acc_q) + $past(step_q))); // R2

  AST_ACC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_vld |=> $stable(acc_q)); // R2

  AST_VLD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (out_vld == $past(sample_vld, 3))); // R6

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((since_rst == 2'd3) && !$past(sample_vld, 3)) |-> ($stable(i_out) && $stable(q_out))); // R7

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> ((i_out != MOST_NEG) && (q_out != MOST_NEG))); // R8

endmodule

bind iq_downmix iq_downmix_chk #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sample_vld (sample_vld),
  .acc_q      (acc_q),
  .step_q     (step_q),
  .out_vld    (out_vld),
  .i_out      (i_out),
  .q_out      (q_out)
);

// File: tb/iq_downmix_tb_top.sv
module iq_downmix_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 16;
  localparam int ACC_W      = 32;
  localparam int TBL_W      = 10;
  localparam real TWO_PI    = 6.283185307179586;

  logic                     clk;
  logic                     rst_n;
  logic                     sample_vld;
  logic signed [DATA_W-1:0] sample_in;
  logic                     cfg_we;
  logic                     cfg_sel;
  logic [ACC_W-1:0]         cfg_wdata;
  logic signed [DATA_W-1:0] i_out;
  logic signed [DATA_W-1:0] q_out;
  logic                     out_vld;

  iq_downmix dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_vld (sample_vld),
    .sample_in  (sample_in),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .i_out      (i_out),
    .q_out      (q_out),
    .out_vld    (out_vld)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int    n_chk;
  int    n_err;
  bit    done;
  logic [ACC_W-1:0] m_acc;
  logic [ACC_W-1:0] m_step;
  logic [ACC_W-1:0] m_off;
  bit    hv [3];
  int    hi [3];
  int    hq [3];
  string ht [3];
  int    prev_i;
  int    prev_q;
  string cur_tag;

  function automatic int rnd_real(input real x);
    if (x >= 0.0) return $rtoi(x + 0.5);
    return -$rtoi(-x + 0.5);
  endfunction

  function automatic int rsat(input longint p);
    longint r;
    r = (p + 64'sd16384) >>> 15;
    if (r > 64'sd32767) return 32767;
    if (r < -64'sd32768) return -32768;
    return int'(r);
  endfunction

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_acc  = '0;
    m_step = '0;
    m_off  = '0;
    for (int k = 0; k < 3; k++) begin
      hv[k] = 1'b0; hi[k] = 0; hq[k] = 0; ht[k] = "R1";
    end
    prev_i = 0;
    prev_q = 0;
  endtask

  // One clock: judge outputs due now, then drive the next inputs.
  task automatic cyc(input bit vld, input int smp, input bit we,
                     input bit sel, input logic [ACC_W-1:0] data);
    logic [ACC_W-1:0] ph;
    int  k;
    real th;
    int  c;
    int  s;
    @(negedge clk);
    check(out_vld == hv[2], "R6", "out_vld", int'(out_vld), int'(hv[2]));
    if (hv[2]) begin
      check(iabs(int'(i_out) - hi[2]) <= 1, ht[2], "i_out", int'(i_out), hi[2]);
      check(iabs(int'(q_out) - hq[2]) <= 1, ht[2], "q_out", int'(q_out), hq[2]);
    end else begin
      check(int'(i_out) == prev_i, "R7", "i_out hold", int'(i_out), prev_i);
      check(int'(q_out) == prev_q, "R7", "q_out hold", int'(q_out), prev_q);
    end
    prev_i = int'(i_out);
    prev_q = int'(q_out);
    for (int j = 2; j > 0; j--) begin
      hv[j] = hv[j-1]; hi[j] = hi[j-1]; hq[j] = hq[j-1]; ht[j] = ht[j-1];
    end
    hv[0] = vld;
    ht[0] = cur_tag;
    if (vld) begin
      ph = m_acc + m_off;
      k  = int'(ph >> (ACC_W - TBL_W));
      th = TWO_PI * (real'(k) + 0.5) / 1024.0;
      c  = rnd_real(32767.0 * $cos(th));
      s  = rnd_real(32767.0 * $sin(th));
      hi[0] = rsat(longint'(smp) * longint'(c));
      hq[0] = rsat(longint'(smp) * longint'(s));
      m_acc = m_acc + m_step;
    end
    if (we) begin
      if (sel) m_off = data;
      else     m_step = data;
    end
    sample_vld = vld;
    sample_in  = DATA_W'(smp);
    cfg_we     = we;
    cfg_sel    = sel;
    cfg_wdata  = data;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      n_err++;
      $display("FAIL R6 watchdog: actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    n_chk = 0;
    n_err = 0;
    done  = 1'b0;
    cur_tag = "R2";
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0;
    sample_vld = 1'b0;
    sample_in = '0;
    cfg_we = 1'b0;
    cfg_sel = 1'b0;
    cfg_wdata = '0;
    model_reset();
    repeat (3) @(negedge clk);
    check(out_vld == 1'b0, "R1", "out_vld in reset", int'(out_vld), 0);
    check(i_out == 0, "R1", "i_out in reset", int'(i_out), 0);
    check(q_out == 0, "R1", "q_out in reset", int'(q_out), 0);
    rst_n = 1'b1;

    // R2: zero increment keeps a constant phase; first sample at phase 0
    cur_tag = "R2";
    for (int n = 0; n < 4; n++) cyc(1'b1, 16384, 1'b0, 1'b0, '0);
    cyc(1'b0, 0, 1'b0, 1'b0, '0);

    // R3: writes coinciding with samples take effect one sample later
    cur_tag = "R3";
    cyc(1'b1, 12000, 1'b1, 1'b0, 32'h0100_0000);
    for (int n = 0; n < 6; n++) cyc(1'b1, 12000 - n * 3000, 1'b0, 1'b0, '0);
    cyc(1'b1, -9000, 1'b1, 1'b1, 32'h4000_0000);
    for (int n = 0; n < 4; n++) cyc(1'b1, -9000, 1'b0, 1'b0, '0);
    cyc(1'b0, 0, 1'b1, 1'b0, 32'h0731_0000);
    for (int n = 0; n < 5; n++) cyc(1'b1, 20000, 1'b0, 1'b0, '0);

    // R8: full-scale samples at many phases
    cur_tag = "R8";
    cyc(1'b1, -32768, 1'b1, 1'b0, 32'h1234_5678);
    for (int n = 0; n < 24; n++) cyc(1'b1, (n % 2) ? 32767 : -32768, 1'b0, 1'b0, '0);

    // R7: sparse samples with long gaps
    cur_tag = "R7";
    for (int n = 0; n < 6; n++) begin
      cyc(1'b1, 7000 + n * 1111, 1'b0, 1'b0, '0);
      repeat (4) cyc(1'b0, 0, 1'b0, 1'b0, '0);
    end

    // R4 R5: random samples, gaps and occasional register writes
    cur_tag = "R5";
    for (int n = 0; n < 3000; n++) begin
      bit v;
      bit w;
      v = ($urandom % 10) < 7;
      w = ($urandom % 20) == 0;
      cyc(v, int'($signed(16'($urandom))), w, 1'($urandom), $urandom);
    end
    repeat (4) cyc(1'b0, 0, 1'b0, 1'b0, '0);

    // R1: reset in mid-run clears accumulator and registers
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(out_vld == 1'b0, "R1", "out_vld after mid reset", int'(out_vld), 0);
    check(i_out == 0, "R1", "i_out after mid reset", int'(i_out), 0);
    check(q_out == 0, "R1", "q_out after mid reset", int'(q_out), 0);
    model_reset();
    rst_n = 1'b1;
    cur_tag = "R1";
    for (int n = 0; n < 3; n++) cyc(1'b1, 20000, 1'b0, 1'b0, '0);
    repeat (4) cyc(1'b0, 0, 1'b0, 1'b0, '0);

    if (!done) begin
      done = 1'b1;
      summary();
      $finish;
    end
  end

endmodule